// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a direct-mapped cache and keeps a short first-in first-out queue of blocks fetched ahead along rising block addresses. It is asked only when the cache misses. The miss address is compared with the tag of the oldest entry and with nothing else. On a match, that block goes to the cache, the entry is freed, and the freed slot is used to fetch the next block in the sequence. If there is no match, every entry is dropped, the missing block is fetched on demand, and fetching ahead starts again from the address after it.

Prefetched blocks stay in the queue until a miss asks for them, so they never displace anything in the cache. The next-level memory answers in request order. Each slot records whether its fetch is still in flight. Responses that belong to a flushed stream are counted and thrown away.

Top module: `seq_stream_buf`

## Requirements
- R1: After reset no memory request is made and no fill is produced until the first lookup arrives.
- R2: A lookup whose address differs from the head tag, or that finds the queue empty, issues one demand request for that address before any prefetch request. It then produces a fill with `fill_hit`=0 and the data returned for that address.
- R3: After a miss at block A, prefetch requests go out for A+1, A+2 and onward in strictly increasing order, wrapping modulo 2^AW. No more than K prefetched blocks are ever held or in flight without having been consumed.
- R4: A lookup that matches the head tag, with the head data present, produces a fill with `fill_hit`=1 and that block's data, and makes no memory request for it.
- R5: After a head hit the freed slot is refilled: the next request is for the block after the last one requested.
- R6: A lookup that matches a head entry whose response has not yet been accepted waits, and its fill comes only after that response has arrived.
- R7: Only the head is compared. A lookup that matches a deeper entry is handled as a miss (`fill_hit`=0) and flushes the queue.
- R8: Responses still in flight when the queue is flushed are discarded. Later hits always deliver the data of the block that was asked for.
- R9: A fill is a one-cycle pulse whose `fill_addr` equals the lookup address. The lookup is held until the fill is seen, and exactly one fill is produced per lookup.
- R10: Once `mreq_valid` is raised without `mreq_ready`, it stays high with the same address until the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache-miss lookup present; held until the fill |
| miss_addr | input | AW | Block address that missed |
| fill_valid | output | 1 | One-cycle fill to the cache |
| fill_hit | output | 1 | 1 = supplied by the buffer, 0 = demand fetched |
| fill_addr | output | AW | Block address of the fill |
| fill_data | output | DW | Block data of the fill |
| mreq_valid | output | 1 | Next-level request valid |
| mreq_ready | input | 1 | Next-level request accepted |
| mreq_addr | output | AW | Requested block address |
| mrsp_valid | input | 1 | Next-level response, in request order |
| mrsp_data | input | DW | Response block data |

## Verification
The assertions assume three things about the environment. The next level answers every accepted request exactly once, in acceptance order. A lookup keeps its address steady until the fill and then drops for at least the cycle after it. No second lookup is raised while a fill is owed. The bench memory model keeps responses in a single ordered queue and varies both latency and the ready pattern. Its lookup driver presents one miss, holds it until the fill, and lowers it in the same half-cycle that the fill is observed.

// File: rtl/seq_stream_buf.sv
module seq_stream_buf #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int K  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          fill_valid,
  output logic          fill_hit,
  output logic [AW-1:0] fill_addr,
  output logic [DW-1:0] fill_data,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic [AW-1:0] mreq_addr,
  input  logic          mrsp_valid,
  input  logic [DW-1:0] mrsp_data
);
  localparam int PW = (K > 1) ? $clog2(K) : 1;
  localparam int CW = $clog2(K + 1);

  logic [AW-1:0] tag_q [K];
  logic [DW-1:0] dat_q [K];
  logic [K-1:0]  vld_q, pend_q;
  logic [PW-1:0] hd_q, tl_q, fp_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   drop_q, drop_n;
  logic [AW-1:0] pf_addr_q;
  logic          pf_en_q, dem_req_q, dem_wait_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(K - 1)) ? '0 : p + PW'(1);
  endfunction

  logic head_ok, eval, take, flush, pf_go, pf_fire, dem_fire;
  logic rsp_drop, rsp_dem, rsp_slot;

  assign head_ok  = vld_q[hd_q] && (tag_q[hd_q] == miss_addr);
  assign eval     = miss_valid && !dem_req_q && !dem_wait_q && !fill_valid;
  assign take     = eval && head_ok && !pend_q[hd_q];
  assign flush    = eval && !head_ok && !(mreq_valid && !mreq_ready);
  assign pf_go    = pf_en_q && (cnt_q < CW'(K)) && !dem_req_q;
  assign mreq_valid = dem_req_q || pf_go;
  assign mreq_addr  = dem_req_q ? miss_addr : pf_addr_q;
  assign dem_fire = dem_req_q && mreq_ready;
  assign pf_fire  = pf_go && mreq_ready;
  assign rsp_drop = mrsp_valid && (drop_q != '0);
  assign rsp_dem  = mrsp_valid && (drop_q == '0) && dem_wait_q;
  assign rsp_slot = mrsp_valid && (drop_q == '0) && !dem_wait_q;

  always_comb begin
    drop_n = drop_q - (CW+1)'(rsp_drop);
    if (flush)
      drop_n = drop_n + (CW+1)'($countones(pend_q)) - (CW+1)'(rsp_slot) + (CW+1)'(pf_fire);
  end

  always_ff @(posedge clk) begin
    if (pf_fire && !flush) tag_q[tl_q] <= pf_addr_q;
    if (rsp_slot) dat_q[fp_q] <= mrsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0; pend_q <= '0;
      hd_q <= '0; tl_q <= '0; fp_q <= '0; cnt_q <= '0;
      drop_q <= '0; pf_addr_q <= '0;
      pf_en_q <= 1'b0; dem_req_q <= 1'b0; dem_wait_q <= 1'b0;
      fill_valid <= 1'b0; fill_hit <= 1'b0; fill_addr <= '0; fill_data <= '0;
    end else begin
      drop_q <= drop_n;
      if (flush) begin
        vld_q <= '0; pend_q <= '0;
        hd_q <= '0; tl_q <= '0; fp_q <= '0; cnt_q <= '0;
        pf_addr_q <= miss_addr + AW'(1);
        pf_en_q <= 1'b1;
        dem_req_q <= 1'b1;
      end else begin
        if (pf_fire) begin
          vld_q[tl_q] <= 1'b1;
          pend_q[tl_q] <= 1'b1;
          tl_q <= nxt(tl_q);
          pf_addr_q <= pf_addr_q + AW'(1);
        end
        if (rsp_slot) begin
          pend_q[fp_q] <= 1'b0;
          fp_q <= nxt(fp_q);
        end
        if (take) begin
          vld_q[hd_q] <= 1'b0;
          hd_q <= nxt(hd_q);
        end
        cnt_q <= cnt_q + CW'(pf_fire) - CW'(take);
        if (dem_fire) begin
          dem_req_q <= 1'b0;
          dem_wait_q <= 1'b1;
        end
        if (rsp_dem) dem_wait_q <= 1'b0;
      end
      fill_valid <= take || rsp_dem;
      fill_hit   <= take;
      fill_addr  <= miss_addr;
      fill_data  <= take ? dat_q[hd_q] : mrsp_data;
    end
  end
endmodule

module ssb_check #(
  parameter int AW = 12,
  parameter int CW = 3,
  parameter int K  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic [AW-1:0] miss_addr,
  input logic          fill_valid,
  input logic [AW-1:0] fill_addr,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic [AW-1:0] mreq_addr,
  input logic [CW-1:0] occ
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (miss_valid) seen_q <= 1'b1;
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!mreq_valid && !fill_valid));

  p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(K));

  p_fill_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);

  p_fill_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ($past(miss_valid) && fill_addr == $past(miss_addr)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));
endmodule

bind seq_stream_buf ssb_check #(.AW(AW), .CW(CW), .K(K)) u_check (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .mreq_valid(mreq_valid),
  .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .occ(cnt_q)
);

// File: tb/seq_stream_buf_bench.sv
module seq_stream_buf_bench;
  localparam int AW = 12, DW = 32, K = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, miss_valid, fill_valid, fill_hit, mreq_valid, mreq_ready, mrsp_valid;
  logic [AW-1:0] miss_addr, fill_addr, mreq_addr;
  logic [DW-1:0] fill_data, mrsp_data;

  seq_stream_buf #(.AW(AW), .DW(DW), .K(K)) u_seq_stream_buf (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .fill_valid(fill_valid), .fill_hit(fill_hit), .fill_addr(fill_addr),
    .fill_data(fill_data), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_addr(mreq_addr), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  int checks = 0, fails = 0, cyc = 0, lat = 2, rdy_pat = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] q[$];
  logic [AW-1:0] memq_a[$];
  int memq_t[$];
  int reqc[1 << AW];
  int dlvc[1 << AW];
  bit started = 0, exp_dem = 0, after_hit = 0;
  bit look = 0, exp_hit = 0, got_fill = 0, deep = 0, pv = 0;
  logic [AW-1:0] dem_addr, exp_pf, look_addr, pa;

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return DW'(a) * 32'h0000_9E37 + 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (fill_valid) begin
      if (!look || got_fill) chk(0, "R9", "unexpected fill", 1, 0);
      else begin
        got_fill = 1;
        chk(fill_addr == look_addr, "R9", "fill address", fill_addr, look_addr);
        chk(fill_hit == exp_hit, deep ? "R7" : (exp_hit ? "R4" : "R2"), "hit flag",
            fill_hit, exp_hit);
        chk(fill_data == blk(look_addr), exp_hit ? "R8" : "R2", "fill data",
            fill_data, blk(look_addr));
        if (exp_hit)
          chk(reqc[look_addr] == dlvc[look_addr], "R6", "block outstanding at hit",
              reqc[look_addr] - dlvc[look_addr], 0);
      end
    end
    if (pv) chk(mreq_valid && mreq_addr == pa, "R10", "request held", mreq_addr, pa);
    mrsp_valid = 1'b0;
    if (memq_a.size() > 0 && cyc - memq_t[0] >= lat) begin
      mrsp_valid = 1'b1;
      mrsp_data = blk(memq_a[0]);
      dlvc[memq_a[0]]++;
      void'(memq_a.pop_front());
      void'(memq_t.pop_front());
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mreq_ready = (rdy_pat == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
    if (mreq_valid && mreq_ready) begin
      pv = 0;
      reqc[mreq_addr]++;
      memq_a.push_back(mreq_addr);
      memq_t.push_back(cyc);
      if (!started) chk(0, "R1", "request before any lookup", mreq_addr, 0);
      else if (exp_dem) begin
        chk(mreq_addr == dem_addr, "R2", "demand address", mreq_addr, dem_addr);
        exp_dem = 0;
      end else begin
        chk(mreq_addr == exp_pf, after_hit ? "R5" : "R3", "prefetch address",
            mreq_addr, exp_pf);
        after_hit = 0;
        q.push_back(exp_pf);
        exp_pf = exp_pf + AW'(1);
        chk(q.size() <= K, "R3", "occupancy", q.size(), K);
      end
    end else begin
      pv = mreq_valid;
      pa = mreq_addr;
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a);
    look_addr = a;
    exp_hit = (q.size() > 0) && (q[0] == a);
    deep = 0;
    if (!exp_hit)
      for (int i = 1; i < q.size(); i++) if (q[i] == a) deep = 1;
    if (exp_hit) begin
      void'(q.pop_front());
      after_hit = 1;
    end else begin
      q.delete();
      exp_dem = 1;
      dem_addr = a;
      exp_pf = a + AW'(1);
      started = 1;
      after_hit = 0;
    end
    miss_valid = 1'b1;
    miss_addr = a;
    look = 1;
    got_fill = 0;
    while (!got_fill) step();
    miss_valid = 1'b0;
    look = 0;
    while (q.size() < K || exp_dem) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0;
    mreq_ready = 1'b0; mrsp_valid = 1'b0; mrsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!mreq_valid && !fill_valid, "R1", "reset state", {mreq_valid, fill_valid}, 0);
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!mreq_valid && !fill_valid, "R1", "idle", {mreq_valid, fill_valid}, 0);
    end
    lookup(12'd100); lookup(12'd101); lookup(12'd102); lookup(12'd103);
    lookup(12'd105);
    lat = 14;
    lookup(12'd300); lookup(12'd301); lookup(12'd302); lookup(12'd303); lookup(12'd304);
    lookup(12'd500); lookup(12'd501); lookup(12'd502);
    rdy_pat = 1; lat = 3;
    lookup(12'd4094); lookup(12'd4095); lookup(12'd0); lookup(12'd1);
    for (int n = 0; n < 40; n++) begin
      lat = 1 + int'(lfsr[3:0]);
      if (lfsr[2:0] < 3'd5) lookup(q[0]);
      else if (lfsr[2:0] == 3'd5) lookup(q[1]);
      else lookup(lfsr[AW-1:0]);
    end
    repeat (30) step();
    summary();
    $finish;
  end
endmodule